// File: doc/BRIEF.md
# Audio Capture Receive FIFO

The block buffers 20-bit samples coming out of an ADC decimation path and hands them to a 32-bit bus reader. Samples enter on a valid strobe and are stored in a 64-entry FIFO. Software takes them out by reading a data register. Each read is formatted for the chosen sample resolution (16 or 20 bits). The result is either left-justified with zero fill or right-justified with sign extension.

A control word sets the behaviour of the block. It holds the capture enable, the resolution and justification, a fill threshold, the interrupt and DMA request enables, a self-clearing flush, and an optional hold-off. The hold-off throws samples away for a chosen number of 1 ms ticks after capture is enabled, so that start-up transients never reach memory.

The block raises a request when its fill level is strictly above the threshold. A write that arrives while the FIFO is full is lost and sets a sticky overrun flag. That flag can drive the interrupt line.

Top module: `capfifo_top`

## Requirements
- R1: After reset, the control word at address 0 reads 0x0000_0400, which gives a threshold of 64 with every other field 0. The fill level, `irq_o` and `dma_req_o` are all 0.
- R2: Writing control bit 0 as 1 empties the FIFO and clears the overrun flag. Bit 0 always reads back as 0.
- R3: Samples are read out in arrival order. `fill_level_o` counts the stored entries, up to 64.
- R4: A sample offered while the FIFO is full, with no pop in the same cycle, is dropped and sets the overrun flag (status address 1, bit 0). Writing 1 to that bit clears the flag.
- R5: Data-available is true exactly when the fill level is strictly greater than control bits 11:4.
- R6: `irq_o` = (overrun AND control bit 1) OR (data-available AND control bit 2). `dma_req_o` = data-available AND control bit 3.
- R7: When control bit 16 = 1 (20-bit samples), a data read returns {entry, 12 zeros} if control bit 24 = 0. If bit 24 = 1, it returns the entry sign-extended from entry bit 19.
- R8: When control bit 16 = 0 (16-bit samples), only entry bits 19:4 are used. They are returned in bits 31:16 with zeros below if bit 24 = 0. If bit 24 = 1, they are returned in bits 15:0 with sign extension above.
- R9: A data read (address 2) while the FIFO is empty returns 0 and leaves the fill level unchanged.
- R10: While control bit 28 (capture enable) is 0, incoming samples are ignored.
- R11: When bit 28 goes from 0 to 1 in a control write that also sets bit 25, samples are discarded until a number of `tick_i` pulses have passed. That number is 5, 10, 20 or 30 for bits 27:26 = 0, 1, 2 or 3.
- R12: Register reads return their data on `reg_rdata_o` one clock after the read strobe. Address 0 returns the control word, address 1 the status, and address 2 pops and returns formatted data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after a read |
| smp_valid_i | input | 1 | Incoming sample strobe |
| smp_data_i | input | 20 | Incoming sample |
| tick_i | input | 1 | 1 ms tick pulse |
| irq_o | output | 1 | Interrupt |
| dma_req_o | output | 1 | DMA request |
| fill_level_o | output | 7 | Stored entry count |

## Verification
The hardest conditions to reach are the full-FIFO edges. One is a sample arriving while all 64 entries are occupied, which must be dropped and must raise overrun. The other is that same arrival coinciding with a pop, which must be accepted. The stimulus fills the FIFO directly, offers an extra sample, and then mixes push-with-read cycles. The hold-off boundary is covered by counting ticks to one short of the selected delay and then exactly to it.

// File: rtl/capfifo_pkg.sv
package capfifo_pkg;
  localparam int SMP_W = 20;
  localparam int BUS_W = 32;

  localparam int B_FLUSH  = 0;
  localparam int B_OVR_IE = 1;
  localparam int B_AV_IE  = 2;
  localparam int B_AV_DE  = 3;
  localparam int B_THR_LO = 4;
  localparam int B_THR_HI = 11;
  localparam int B_RES20  = 16;
  localparam int B_SEXT   = 24;
  localparam int B_DLY_EN = 25;
  localparam int B_DLY_LO = 26;
  localparam int B_DLY_HI = 27;
  localparam int B_RUN    = 28;

  localparam logic [BUS_W-1:0] CTL_RESET = 32'h0000_0400;
  localparam logic [BUS_W-1:0] CTL_MASK  = 32'h1F01_0FFE;

  typedef enum logic [1:0] {
    A_CTL  = 2'd0,
    A_STAT = 2'd1,
    A_DATA = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/capfifo_mem.sv
module capfifo_mem #(
  parameter int DEPTH = 64,
  parameter int W     = 20,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [W-1:0]     wdata_i,
  output logic [W-1:0]     rdata_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);

  // R3: occupancy never exceeds depth
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  // R4: a push into a full FIFO only with a simultaneous pop
  p_push_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !flush_i) |-> pop_i);
  // R2: flush empties
  p_flush_empty_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/capfifo_holdoff.sv
module capfifo_holdoff #(
  parameter int DLY_UNIT = 5,
  localparam int CNT_W = $clog2(DLY_UNIT * 6 + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       start_i,
  input  logic       dly_en_i,
  input  logic [1:0] sel_i,
  input  logic       tick_i,
  output logic       hold_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  // 1, 2, 4, 6 units
  always_comb begin
    case (sel_i)
      2'd0:    load_val = CNT_W'(DLY_UNIT);
      2'd1:    load_val = CNT_W'(DLY_UNIT * 2);
      2'd2:    load_val = CNT_W'(DLY_UNIT * 4);
      default: load_val = CNT_W'(DLY_UNIT * 6);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (start_i)                 cnt_q <= dly_en_i ? load_val : '0;
    else if (!en_i)                   cnt_q <= '0;
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign hold_o = (cnt_q != '0);

  // R11: hold-off armed by a delayed enable
  p_hold_arm_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && dly_en_i) |=> hold_o);
  // R11: countdown never grows without a restart
  p_hold_mono_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> cnt_q <= $past(cnt_q));
endmodule

// File: rtl/capfifo_fmt.sv
module capfifo_fmt #(
  parameter int SMP_W = 20,
  parameter int BUS_W = 32
) (
  input  logic [SMP_W-1:0] entry_i,
  input  logic             valid_i,
  input  logic             res20_i,
  input  logic             sext_i,
  output logic [BUS_W-1:0] word_o
);
  localparam int NARROW = SMP_W - 4;

  logic [NARROW-1:0] narrow;
  assign narrow = entry_i[SMP_W-1:4];

  always_comb begin
    if (!valid_i)     word_o = '0;
    else if (res20_i) word_o = sext_i ? {{(BUS_W-SMP_W){entry_i[SMP_W-1]}}, entry_i}
                                      : {entry_i, {(BUS_W-SMP_W){1'b0}}};
    else              word_o = sext_i ? {{(BUS_W-NARROW){narrow[NARROW-1]}}, narrow}
                                      : {narrow, {(BUS_W-NARROW){1'b0}}};
  end
endmodule

// File: rtl/capfifo_top.sv
module capfifo_top
  import capfifo_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int DLY_UNIT = 5,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  input  logic             smp_valid_i,
  input  logic [19:0]      smp_data_i,
  input  logic             tick_i,
  output logic             irq_o,
  output logic             dma_req_o,
  output logic [CNT_W-1:0] fill_level_o
);
  logic [BUS_W-1:0] ctl_q, rdata_q, fmt_word;
  logic             ovr_q;
  logic             wr_ctl, wr_stat, rd_data, flush, start, run, hold;
  logic             smp_try, push, pop, full, empty, avail;
  logic [SMP_W-1:0] head;
  logic [CNT_W-1:0] count;
  logic [7:0]       thr;

  assign wr_ctl  = reg_wr_i && (reg_addr_i == A_CTL);
  assign wr_stat = reg_wr_i && (reg_addr_i == A_STAT);
  assign rd_data = reg_rd_i && (reg_addr_i == A_DATA);
  assign flush   = wr_ctl && reg_wdata_i[B_FLUSH];
  assign run     = ctl_q[B_RUN];
  assign start   = wr_ctl && reg_wdata_i[B_RUN] && !run;
  assign thr     = ctl_q[B_THR_HI:B_THR_LO];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctl_q <= CTL_RESET;
    else if (wr_ctl) ctl_q <= reg_wdata_i & CTL_MASK;
  end

  capfifo_holdoff #(.DLY_UNIT(DLY_UNIT)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (run),
    .start_i  (start),
    .dly_en_i (reg_wdata_i[B_DLY_EN]),
    .sel_i    (reg_wdata_i[B_DLY_HI:B_DLY_LO]),
    .tick_i   (tick_i),
    .hold_o   (hold)
  );

  assign pop     = rd_data && !empty;
  assign smp_try = smp_valid_i && run && !hold && !flush;
  assign push    = smp_try && (!full || pop);

  capfifo_mem #(.DEPTH(DEPTH), .W(SMP_W)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (push),
    .pop_i   (pop),
    .wdata_i (smp_data_i),
    .rdata_o (head),
    .count_o (count),
    .full_o  (full),
    .empty_o (empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            ovr_q <= 1'b0;
    else if (flush)                         ovr_q <= 1'b0;
    else if (smp_try && full && !pop)       ovr_q <= 1'b1;
    else if (wr_stat && reg_wdata_i[0])     ovr_q <= 1'b0;
  end

  capfifo_fmt #(.SMP_W(SMP_W), .BUS_W(BUS_W)) u_fmt (
    .entry_i (head),
    .valid_i (!empty),
    .res20_i (ctl_q[B_RES20]),
    .sext_i  (ctl_q[B_SEXT]),
    .word_o  (fmt_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (reg_rd_i) begin
      case (reg_addr_i)
        A_CTL:   rdata_q <= ctl_q;
        A_STAT:  rdata_q <= {{(BUS_W-1){1'b0}}, ovr_q};
        A_DATA:  rdata_q <= fmt_word;
        default: rdata_q <= '0;
      endcase
    end
  end

  assign avail        = ({{(32-CNT_W){1'b0}}, count} > {24'b0, thr});
  assign irq_o        = (ovr_q && ctl_q[B_OVR_IE]) || (avail && ctl_q[B_AV_IE]);
  assign dma_req_o    = avail && ctl_q[B_AV_DE];
  assign fill_level_o = count;
  assign reg_rdata_o  = rdata_q;

  // R2: flush bit never reads back set
  p_flush_selfclr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == A_CTL) |=> !reg_rdata_o[B_FLUSH]);
  // R2: flush drops the overrun flag
  p_flush_ovr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> !ovr_q);
  // R4: dropped sample raises overrun
  p_ovr_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_try && full && !pop) |=> ovr_q);
  // R9: empty read returns zero, level unchanged
  p_empty_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && empty && !smp_try) |=> (reg_rdata_o == '0) && (fill_level_o == '0));
  // R10: no growth while disabled
  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !flush) |=> fill_level_o <= $past(fill_level_o));
endmodule

// File: tb/capfifo_top_test.sv
module capfifo_top_test;
  localparam int CLK_T = 10;
  localparam int DEPTH = 64;

  logic        clk = 0, rst_n = 0;
  logic        wr = 0, rd = 0, sv = 0, tk = 0;
  logic [1:0]  addr = 0;
  logic [31:0] wd = 0;
  logic [19:0] sd = 0;
  logic [31:0] rdata;
  logic        irq, dma;
  logic [6:0]  fill;

  capfifo_top uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wd), .reg_rdata_o(rdata), .smp_valid_i(sv), .smp_data_i(sd),
    .tick_i(tk), .irq_o(irq), .dma_req_o(dma), .fill_level_o(fill)
  );

  always #(CLK_T/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // model state
  logic [31:0] m_ctl = 32'h400;
  logic [19:0] m_q[$];
  bit          m_ovr = 0;
  int          m_hold = 0;
  logic [31:0] m_rd = 0;

  function automatic logic [31:0] exp_fmt(logic [19:0] e, bit r20, bit sx);
    logic [15:0] s;
    s = e[19:4];
    if (r20) return sx ? {{12{e[19]}}, e} : {e, 12'h000};
    return sx ? {{16{s[15]}}, s} : {s, 16'h0000};
  endfunction

  function automatic int dly_ticks(logic [1:0] sel);
    case (sel)
      2'd0: return 5;
      2'd1: return 10;
      2'd2: return 20;
      default: return 30;
    endcase
  endfunction

  function automatic bit m_avail();
    return m_q.size() > int'(m_ctl[11:4]);
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one clock: drive at negedge, model the edge, release at next negedge
  task automatic cyc(bit w, bit r, logic [1:0] a, logic [31:0] d, bit v, logic [19:0] s, bit t);
    bit flush, popok, try_, start, ovf;
    @(negedge clk);
    wr = w; rd = r; addr = a; wd = d; sv = v; sd = s; tk = t;
    flush = w && a == 2'd0 && d[0];
    popok = r && a == 2'd2 && m_q.size() > 0;
    try_  = v && m_ctl[28] && m_hold == 0 && !flush;
    start = w && a == 2'd0 && d[28] && !m_ctl[28];
    ovf   = 0;
    if (r) begin
      case (a)
        2'd0: m_rd = m_ctl;
        2'd1: m_rd = {31'b0, m_ovr};
        2'd2: m_rd = (m_q.size() > 0) ? exp_fmt(m_q[0], m_ctl[16], m_ctl[24]) : 32'h0;
        default: m_rd = 0;
      endcase
    end
    if (flush) begin
      m_q.delete();
      m_ovr = 0;
    end else begin
      if (popok) void'(m_q.pop_front());
      if (try_) begin
        if (m_q.size() < DEPTH) m_q.push_back(s);
        else begin m_ovr = 1; ovf = 1; end
      end
      if (!ovf && w && a == 2'd1 && d[0]) m_ovr = 0;
    end
    if (start) m_hold = d[25] ? dly_ticks(d[27:26]) : 0;
    else if (!m_ctl[28]) m_hold = 0;
    else if (t && m_hold > 0) m_hold--;
    if (w && a == 2'd0) m_ctl = d & 32'h1F01_0FFE;
    @(negedge clk);
    wr = 0; rd = 0; sv = 0; tk = 0;
  endtask

  task automatic chk_outs(string tag);
    chk({tag, " fill"}, {25'b0, fill}, m_q.size());
    chk({tag, " irq"}, {31'b0, irq},
        {31'b0, (m_ovr && m_ctl[1]) || (m_avail() && m_ctl[2])});
    chk({tag, " dma"}, {31'b0, dma}, {31'b0, m_avail() && m_ctl[3]});
  endtask

  task automatic wr_ctl(logic [31:0] d); cyc(1, 0, 2'd0, d, 0, 0, 0); endtask
  task automatic push(logic [19:0] s);   cyc(0, 0, 2'd0, 0, 1, s, 0); endtask
  task automatic rd_reg(logic [1:0] a);  cyc(0, 1, a, 0, 0, 0, 0); endtask
  task automatic tick();                 cyc(0, 0, 2'd0, 0, 0, 0, 1); endtask

  initial begin
    #(CLK_T * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 fill", {25'b0, fill}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 dma", {31'b0, dma}, 0);
    rd_reg(2'd0);
    chk("R1 ctl", rdata, 32'h0000_0400);

    // R10 disabled ignores samples
    push(20'h12345);
    chk("R10 disabled", {25'b0, fill}, 0);

    // R7 20-bit formats; R12 register read timing
    wr_ctl(32'h1001_0000);
    push(20'hABCDE);
    chk("R3 one entry", {25'b0, fill}, 1);
    rd_reg(2'd2);
    chk("R7 left20", rdata, 32'hABCD_E000);
    wr_ctl(32'h1101_0000);
    push(20'h80001);
    rd_reg(2'd2);
    chk("R7 sext20", rdata, 32'hFFF8_0001);
    // R8 16-bit formats
    wr_ctl(32'h1000_0000);
    push(20'h12345);
    rd_reg(2'd2);
    chk("R8 left16", rdata, 32'h1234_0000);
    wr_ctl(32'h1100_0000);
    push(20'h87654);
    rd_reg(2'd2);
    chk("R8 sext16", rdata, 32'hFFFF_8765);
    // R9 empty read
    rd_reg(2'd2);
    chk("R9 empty data", rdata, 0);
    chk("R9 empty fill", {25'b0, fill}, 0);

    // R5/R6 threshold 3, irq+dma enabled
    wr_ctl(32'h1001_003C);
    for (int i = 0; i < 3; i++) push(20'(i + 1));
    chk("R5 at thr irq", {31'b0, irq}, 0);
    chk("R5 at thr dma", {31'b0, dma}, 0);
    push(20'h4);
    chk("R5 above thr irq", {31'b0, irq}, 1);
    chk("R6 dma", {31'b0, dma}, 1);
    wr_ctl(32'h1001_0034);
    chk("R6 dma off", {31'b0, dma}, 0);
    chk("R6 irq only", {31'b0, irq}, 1);

    // R4 overrun at full; R5 default threshold 64 never met
    wr_ctl(32'h1001_0402);
    for (int i = 4; i < DEPTH; i++) push(20'(i + 1));
    chk("R3 full", {25'b0, fill}, 64);
    chk("R5 thr64 full", {31'b0, irq}, 0);
    push(20'hFFFFF);
    chk("R4 dropped", {25'b0, fill}, 64);
    rd_reg(2'd1);
    chk("R4 flag", rdata, 1);
    chk("R6 ovr irq", {31'b0, irq}, 1);
    cyc(0, 1, 2'd2, 0, 1, 20'h55555, 0);
    chk("R3 order head", rdata, exp_fmt(20'h1, 1, 0));
    chk("R4 push+pop accepted", {25'b0, fill}, 64);
    cyc(1, 0, 2'd1, 32'h1, 0, 0, 0);
    rd_reg(2'd1);
    chk("R4 w1c", rdata, 0);
    chk_outs("R6 after clear");

    // R2 flush
    push(20'h1);
    rd_reg(2'd1);
    chk("R4 reraise", rdata, 1);
    wr_ctl(32'h1001_0401);
    chk("R2 flushed", {25'b0, fill}, 0);
    rd_reg(2'd0);
    chk("R2 selfclear", rdata, 32'h1001_0400);
    rd_reg(2'd1);
    chk("R2 ovr cleared", rdata, 0);

    // R11 hold-off, 5 ticks
    wr_ctl(32'h0001_0000);
    wr_ctl(32'h1201_0000);
    push(20'h11111);
    chk("R11 held", {25'b0, fill}, 0);
    repeat (4) tick();
    push(20'h22222);
    chk("R11 held 4 ticks", {25'b0, fill}, 0);
    tick();
    push(20'h33333);
    chk("R11 released", {25'b0, fill}, 1);
    rd_reg(2'd2);
    chk("R11 data", rdata, 32'h3333_3000);
    // R11 hold-off, 30 ticks
    wr_ctl(32'h0001_0000);
    wr_ctl(32'h1E01_0000);
    repeat (29) tick();
    push(20'h44444);
    chk("R11 held 29", {25'b0, fill}, 0);
    tick();
    push(20'h55555);
    chk("R11 released 30", {25'b0, fill}, 1);

    // random phase: R3 R5 R6 R7 R8
    wr_ctl(32'h1001_00FE);
    for (int n = 0; n < 2000; n++) begin
      int op;
      op = $urandom % 16;
      if (op < 7) push(20'($urandom));
      else if (op < 11) begin
        rd_reg(2'd2);
        chk("R3 rand data", rdata, m_rd);
      end else if (op < 13) begin
        cyc(0, 1, 2'd2, 0, 1, 20'($urandom), 0);
        chk("R3 rand push+pop", rdata, m_rd);
      end else if (op < 15) begin
        logic [31:0] c;
        c = 32'h1000_0000 | ($urandom & 32'h0101_07FE);
        if ($urandom % 10 == 0) c[0] = 1;
        wr_ctl(c);
      end else begin
        rd_reg(2'd1);
        chk("R4 rand flag", rdata, m_rd);
      end
      chk_outs("R5 rand");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule